// File: doc/BRIEF.md
# Shared Multiply and Shift Unit for Two Cores

This block serves two small processor cores with one 32×32 unsigned multiplier that yields a 64-bit product. The same multiplier also performs logical shifts. For a left shift by k, the unit multiplies A by 2^k and keeps the low product word. For a right shift by k, it multiplies A by 2^(32−k) and keeps the high word. A right shift by zero is handled as a direct pass of A, because 2^32 does not fit in a 32-bit operand. A one-hot decoder builds the power-of-two operand from the shift amount.

Each core has a valid/ready request port carrying a 2-bit opcode, operand A and operand B. For shifts, B supplies the shift amount. Back-pressure rules:

- A core raises valid and must hold the opcode and operands stable until ready is seen high in the same cycle.
- Ready depends on the valid inputs of both cores.
- Only one operation is in flight at a time, because the multiplier is not pipelined.
- The response is a one-cycle done pulse with a 32-bit result. It goes only to the core that issued the request.
- The response has no back-pressure.

When both cores request in the same idle cycle, the grant alternates between them.

Top module: `shared_mul_shift`

## Requirements
- R1: After reset, both done outputs are low. When both cores request at once for the first time after reset, core 0 is served first.
- R2: Opcode 0 returns the low 32 bits of the unsigned product A×B.
- R3: Opcode 1 returns the high 32 bits of the unsigned product A×B.
- R4: Opcode 2 returns A shifted left logically by k, where k is B bits 4:0 and the upper bits of B are ignored. With k = 0 the result is A.
- R5: Opcode 3 with k in 1..31 returns A shifted right logically by k, with zeros entering from the top.
- R6: Opcode 3 with k = 0 returns A unchanged.
- R7: After a request is accepted on a clock edge, done rises after the LATENCY-th following edge and stays high for exactly one cycle.
- R8: Done and the result reach only the core whose request was accepted. The other core's done stays low.
- R9: At most one request is accepted per edge. From that acceptance until the done cycle, neither core sees ready.
- R10: When the unit is idle and one core requests, that core is accepted at once. When both request, the core that was not served by the previous acceptance wins.
- R11: Operands are captured on acceptance. Later changes on any core's request inputs do not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_valid | input | 1 | Core 0 request valid |
| c0_ready | output | 1 | Core 0 request accepted this cycle when valid is high |
| c0_op | input | 2 | Core 0 opcode: 0 mul low, 1 mul high, 2 shift left, 3 shift right |
| c0_a | input | 32 | Core 0 operand A |
| c0_b | input | 32 | Core 0 operand B or shift amount in bits 4:0 |
| c0_done | output | 1 | Core 0 one-cycle completion pulse |
| c0_result | output | 32 | Core 0 result, meaningful while c0_done is high |
| c1_valid | input | 1 | Core 1 request valid |
| c1_ready | output | 1 | Core 1 request accepted this cycle when valid is high |
| c1_op | input | 2 | Core 1 opcode, same encoding as core 0 |
| c1_a | input | 32 | Core 1 operand A |
| c1_b | input | 32 | Core 1 operand B or shift amount in bits 4:0 |
| c1_done | output | 1 | Core 1 one-cycle completion pulse |
| c1_result | output | 32 | Core 1 result, meaningful while c1_done is high |

## Verification
Suppose a request is accepted on edge E. Its done pulse and result are due in the cycle after edge E+LATENCY, and ready may return in that same cycle, so the next acceptance can come no earlier than edge E+LATENCY+1. The bench keeps a behavioural model that counts these edges. On every falling clock edge it compares both ready lines, both done lines and, when done is expected, the result. Outputs are therefore sampled half a cycle after the edge that produced them, and new stimulus is applied only after that comparison.

// File: rtl/mss_pkg.sv
package mss_pkg;
  // Opcode encoding shared by both request ports.
  typedef enum logic [1:0] {
    OP_MUL_LO = 2'd0,
    OP_MUL_HI = 2'd1,
    OP_SHL    = 2'd2,
    OP_SHR    = 2'd3
  } mss_op_e;

  // Result selection decided at operand preparation, carried with the job.
  typedef struct packed {
    logic take_hi;  // keep upper product word
    logic pass_a;   // bypass product and return operand A
  } mss_sel_t;
endpackage

// File: rtl/mss_rr_arb.sv
module mss_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       idle,
  output logic [1:0] gnt
);
  // favor_c1 high means core 1 wins a tie on the next contention.
  logic favor_c1;

  always_comb begin
    gnt[0] = idle & req[0] & (~req[1] | ~favor_c1);
    gnt[1] = idle & req[1] & (~req[0] |  favor_c1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      favor_c1 <= 1'b0;
    end else if (|gnt) begin
      favor_c1 <= gnt[0];
    end
  end
endmodule

// File: rtl/mss_pow2_dec.sv
module mss_pow2_dec #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [SHAMT_W-1:0] exp_in,
  output logic [DATA_W-1:0]  pow2
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    assign pow2[j] = (exp_in == SHAMT_W'(j));
  end
endmodule

// File: rtl/mss_operand_prep.sv
module mss_operand_prep
  import mss_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  mss_op_e            op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  opa,
  output logic [DATA_W-1:0]  opb,
  output mss_sel_t           sel
);
  logic [SHAMT_W-1:0] amt;
  logic [SHAMT_W-1:0] exp_sel;
  logic [DATA_W-1:0]  pow2;

  assign amt = b[SHAMT_W-1:0];

  // Right shift by k uses exponent DATA_W-k; DATA_W is a power of two,
  // so the wrap of the subtraction gives exactly that value for k>0.
  always_comb begin
    if (op == OP_SHR) exp_sel = SHAMT_W'(0) - amt;
    else              exp_sel = amt;
  end

  mss_pow2_dec #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dec (
    .exp_in (exp_sel),
    .pow2   (pow2)
  );

  always_comb begin
    opa         = a;
    opb         = b;
    sel.take_hi = 1'b0;
    sel.pass_a  = 1'b0;
    unique case (op)
      OP_MUL_LO: begin
        opb = b;
      end
      OP_MUL_HI: begin
        opb         = b;
        sel.take_hi = 1'b1;
      end
      OP_SHL: begin
        opb = pow2;
      end
      OP_SHR: begin
        opb         = pow2;
        sel.take_hi = 1'b1;
        sel.pass_a  = (amt == '0);
      end
      default: opb = b;
    endcase
  end
endmodule

// File: rtl/mss_mul_unit.sv
module mss_mul_unit
  import mss_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 2,
  localparam int LAT_W  = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              owner_in,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  mss_sel_t          sel_in,
  output logic              busy,
  output logic [1:0]        done,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0]   ra, rb;
  mss_sel_t            rsel;
  logic                own;
  logic [LAT_W-1:0]    cnt;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   pick;

  // Operands stay still for LATENCY cycles, so the product may settle
  // over that many cycles.
  assign prod = {{DATA_W{1'b0}}, ra} * {{DATA_W{1'b0}}, rb};

  always_comb begin
    if (rsel.pass_a)       pick = ra;
    else if (rsel.take_hi) pick = prod[2*DATA_W-1:DATA_W];
    else                   pick = prod[DATA_W-1:0];
  end

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra     <= '0;
      rb     <= '0;
      rsel   <= '0;
      own    <= 1'b0;
      cnt    <= '0;
      done   <= '0;
      result <= '0;
    end else begin
      done <= '0;
      if (start) begin
        ra   <= opa;
        rb   <= opb;
        rsel <= sel_in;
        own  <= owner_in;
        cnt  <= LAT_W'(LATENCY);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (cnt == LAT_W'(1)) begin
        done[own] <= 1'b1;
        result    <= pick;
      end
    end
  end
endmodule

// File: rtl/shared_mul_shift.sv
module shared_mul_shift
  import mss_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c0_valid,
  output logic              c0_ready,
  input  logic [1:0]        c0_op,
  input  logic [DATA_W-1:0] c0_a,
  input  logic [DATA_W-1:0] c0_b,
  output logic              c0_done,
  output logic [DATA_W-1:0] c0_result,
  input  logic              c1_valid,
  output logic              c1_ready,
  input  logic [1:0]        c1_op,
  input  logic [DATA_W-1:0] c1_a,
  input  logic [DATA_W-1:0] c1_b,
  output logic              c1_done,
  output logic [DATA_W-1:0] c1_result
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [1:0]        gnt;
  logic              busy;
  mss_op_e           win_op;
  logic [DATA_W-1:0] win_a, win_b;
  logic [DATA_W-1:0] opa, opb;
  mss_sel_t          sel;
  logic [1:0]        done;
  logic [DATA_W-1:0] result;

  mss_rr_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   ({c1_valid, c0_valid}),
    .idle  (~busy),
    .gnt   (gnt)
  );

  assign c0_ready = gnt[0];
  assign c1_ready = gnt[1];

  always_comb begin
    if (gnt[1]) begin
      win_op = mss_op_e'(c1_op);
      win_a  = c1_a;
      win_b  = c1_b;
    end else begin
      win_op = mss_op_e'(c0_op);
      win_a  = c0_a;
      win_b  = c0_b;
    end
  end

  mss_operand_prep #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_prep (
    .op  (win_op),
    .a   (win_a),
    .b   (win_b),
    .opa (opa),
    .opb (opb),
    .sel (sel)
  );

  mss_mul_unit #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (|gnt),
    .owner_in (gnt[1]),
    .opa      (opa),
    .opb      (opb),
    .sel_in   (sel),
    .busy     (busy),
    .done     (done),
    .result   (result)
  );

  assign c0_done   = done[0];
  assign c1_done   = done[1];
  assign c0_result = result;
  assign c1_result = result;
endmodule

// File: rtl/shared_mul_shift_chk.sv
module shared_mul_shift_chk #(
  parameter int LATENCY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic c0_valid,
  input logic c0_ready,
  input logic c0_done,
  input logic c1_valid,
  input logic c1_ready,
  input logic c1_done
);
  localparam int CW = $clog2(LATENCY + 2) + 1;

  logic          acc0, acc1;
  logic [CW-1:0] since;
  logic          own;
  logic          last_win;

  assign acc0 = c0_valid & c0_ready;
  assign acc1 = c1_valid & c1_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since    <= '0;
      own      <= 1'b0;
      last_win <= 1'b1;
    end else if (acc0 | acc1) begin
      since    <= CW'(1);
      own      <= acc1;
      last_win <= acc1;
    end else if (since != '0) begin
      since <= (since == CW'(LATENCY + 1)) ? '0 : since + 1'b1;
    end
  end

  p_single_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc0 && acc1)) else $error("two accepts in one cycle");

  p_blocked_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc0 || acc1) |=> (!c0_ready && !c1_ready)) else $error("ready while busy");

  p_done_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c0_done, c1_done})) else $error("done to both cores");

  p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_done || c1_done) |-> (since == CW'(LATENCY + 1))) else $error("done at wrong cycle");

  p_done_owner0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c0_done |-> !own) else $error("core 0 done for core 1 job");

  p_done_owner1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c1_done |-> own) else $error("core 1 done for core 0 job");

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_done || c1_done) |=> (!c0_done && !c1_done)) else $error("done longer than one cycle");

  p_round_robin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_valid && c1_valid && (c0_ready || c1_ready)) |-> (c0_ready == last_win))
    else $error("tie not alternated");
endmodule

bind shared_mul_shift shared_mul_shift_chk #(.LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .c0_valid (c0_valid),
  .c0_ready (c0_ready),
  .c0_done  (c0_done),
  .c1_valid (c1_valid),
  .c1_ready (c1_ready),
  .c1_done  (c1_done)
);

// File: tb/tb_shared_mul_shift.sv
module tb_shared_mul_shift;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        v  [2];
  logic [1:0]  o  [2];
  logic [31:0] aa [2];
  logic [31:0] bb [2];
  logic        c0_ready, c1_ready, c0_done, c1_done;
  logic [31:0] c0_result, c1_result;

  shared_mul_shift #(.DATA_W(32), .LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .c0_valid(v[0]), .c0_ready(c0_ready), .c0_op(o[0]), .c0_a(aa[0]), .c0_b(bb[0]),
    .c0_done(c0_done), .c0_result(c0_result),
    .c1_valid(v[1]), .c1_ready(c1_ready), .c1_op(o[1]), .c1_a(aa[1]), .c1_b(bb[1]),
    .c1_done(c1_done), .c1_result(c1_result)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1_reset";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%h expected=%h", tag, phase, what, act, exp);
    end
  endtask

  // Reference arithmetic taken from the requirements.
  function automatic logic [31:0] ref_calc(input logic [1:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [63:0] p;
    int k;
    p = {32'd0, a} * {32'd0, b};
    k = int'(b[4:0]);
    case (op)
      2'd0:    return p[31:0];   // R2
      2'd1:    return p[63:32];  // R3
      2'd2:    return a << k;    // R4
      default: return a >> k;    // R5, R6
    endcase
  endfunction

  function automatic string ref_tag(input logic [1:0] op, input logic [31:0] b);
    case (op)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return (b[4:0] == 5'd0) ? "R6" : "R5";
    endcase
  endfunction

  // Behavioural model, advanced on every rising edge.
  int          m_cnt;
  int          m_own;
  bit          m_prio;
  logic [31:0] m_res;
  string       m_tag;
  bit          m_acc [2];
  bit          e_done [2];
  logic [31:0] e_res;
  string       e_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_own = 0; m_prio = 0;
      m_acc[0] = 0; m_acc[1] = 0; e_done[0] = 0; e_done[1] = 0;
    end else begin
      int g;
      g = -1;
      e_done[0] = 0; e_done[1] = 0;
      m_acc[0] = 0; m_acc[1] = 0;
      if (m_cnt == 1) begin
        e_done[m_own] = 1;
        e_res = m_res;
        e_tag = m_tag;
      end
      if (m_cnt != 0) m_cnt--;
      else begin
        if (v[0] && v[1]) g = m_prio ? 1 : 0;
        else if (v[0])    g = 0;
        else if (v[1])    g = 1;
        if (g >= 0) begin
          m_acc[g] = 1;
          m_cnt  = LAT;
          m_own  = g;
          m_res  = ref_calc(o[g], aa[g], bb[g]);
          m_tag  = ref_tag(o[g], bb[g]);
          m_prio = (g == 0);
        end
      end
    end
  end

  // Stimulus sources.
  logic [31:0] lcg = 32'h1357_9bdf;
  function automatic logic [31:0] step(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  int  rem [2];
  int  mode = 0;      // 0 random, 1 directed list on core 0
  bit  gaps = 0;      // insert idle cycles with scrambled inputs
  int  didx = 0;

  task automatic directed(input int i, output logic [1:0] op, output logic [31:0] a,
                          output logic [31:0] b);
    case (i)
      0:  begin op = 2'd0; a = 32'hffff_ffff; b = 32'hffff_ffff; end
      1:  begin op = 2'd1; a = 32'hffff_ffff; b = 32'hffff_ffff; end
      2:  begin op = 2'd0; a = 32'h1234_5678; b = 32'h9abc_def0; end
      3:  begin op = 2'd2; a = 32'h8000_0001; b = 32'd0;         end
      4:  begin op = 2'd2; a = 32'h8000_0001; b = 32'd1;         end
      5:  begin op = 2'd2; a = 32'hdead_beef; b = 32'hffff_ffff; end
      6:  begin op = 2'd3; a = 32'h8000_0000; b = 32'd31;        end
      7:  begin op = 2'd3; a = 32'hdead_beef; b = 32'd0;         end
      8:  begin op = 2'd3; a = 32'hdead_beef; b = 32'd4;         end
      9:  begin op = 2'd3; a = 32'hdead_beef; b = 32'hffff_ffe4; end
      default: begin op = 2'd1; a = 32'd0; b = 32'h7777_7777; end
    endcase
  endtask

  task automatic drive(input int i);
    logic [1:0]  op;
    logic [31:0] a, b;
    if (v[i] && !m_acc[i]) return;  // hold until accepted
    lcg = step(lcg); a = lcg;
    lcg = step(lcg); b = lcg;
    lcg = step(lcg); op = lcg[31:30];
    if (lcg[3:1] == 3'd0) b[4:0] = 5'd0;
    if (rem[i] == 0 || (gaps && lcg[9])) begin
      v[i] = 0; o[i] = op; aa[i] = a; bb[i] = b;  // idle: garbage operands (R11)
      return;
    end
    if (mode == 1 && i == 0) begin
      directed(didx, op, a, b);
      didx++;
    end
    v[i] = 1; o[i] = op; aa[i] = a; bb[i] = b;
    rem[i]--;
  endtask

  // Compare on every falling edge, then apply new stimulus.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit er0, er1;
      er0 = (m_cnt == 0) && v[0] && (!v[1] || !m_prio);
      er1 = (m_cnt == 0) && v[1] && (!v[0] ||  m_prio);
      check(c0_ready == er0, (m_cnt != 0) ? "R9" : "R10", "c0_ready", 32'(c0_ready), 32'(er0));
      check(c1_ready == er1, (m_cnt != 0) ? "R9" : "R10", "c1_ready", 32'(c1_ready), 32'(er1));
      check(c0_done == e_done[0], (m_own == 0) ? "R7" : "R8", "c0_done", 32'(c0_done), 32'(e_done[0]));
      check(c1_done == e_done[1], (m_own == 1) ? "R7" : "R8", "c1_done", 32'(c1_done), 32'(e_done[1]));
      if (e_done[0]) check(c0_result == e_res, gaps ? "R11" : e_tag, "c0_result", c0_result, e_res);
      if (e_done[1]) check(c1_result == e_res, gaps ? "R11" : e_tag, "c1_result", c1_result, e_res);
      drive(0);
      drive(1);
    end
  end

  task automatic run_phase(input string name, input int n0, input int n1,
                           input int md, input bit gp);
    phase = name; mode = md; gaps = gp; didx = 0;
    rem[0] = n0; rem[1] = n1;
    do @(negedge clk);
    while (rem[0] != 0 || rem[1] != 0 || v[0] || v[1] || m_cnt != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    v[0] = 0; v[1] = 0; o[0] = 0; o[1] = 0;
    aa[0] = 0; aa[1] = 0; bb[0] = 0; bb[1] = 0;
    rem[0] = 0; rem[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(c0_done == 1'b0, "R1", "c0_done in reset", 32'(c0_done), 32'd0);
    check(c1_done == 1'b0, "R1", "c1_done in reset", 32'(c1_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(c0_done == 1'b0 && c1_done == 1'b0, "R1", "done after reset",
          32'({c1_done, c0_done}), 32'd0);
    // R1 first tie goes to core 0; R10 alternation under continuous contention
    run_phase("R10_contention", 30, 30, 0, 0);
    // R2..R6 corner values on core 0 alone
    run_phase("R2_R6_directed", 11, 0, 1, 0);
    // R11 inputs scrambled while a job is in flight
    run_phase("R11_scramble", 25, 25, 0, 1);
    // R8 mixed traffic
    run_phase("R8_mixed", 40, 40, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, cycles, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule